// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block runs conversion sequences for an external successive-approximation converter that serves eight analog inputs. Software programs a configuration word, selects the inputs it wants, and then starts a scan with a control write or with a rising edge on one of eight hardware trigger lines. The sequencer waits out a warm-up period if the converter is asleep. It then visits every selected input from the lowest number to the highest. For each input it holds a sampling window and then asks the converter for one result through a request/acknowledge handshake.

Every result lands in a per-input data register and in a shared "most recent" register. Per-input completion flags, per-input overrun flags and one global ready flag record the outcome. An interrupt line is formed from these flags and an enable mask. All timing is counted in converter-clock ticks. Each tick lasts (PRESCAL+1)*2 system clocks, and the tick counter restarts at every phase change, so every delay is an exact number of system cycles.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, `conv_req` is low and `irq` is low.
- R2: Word address 1 holds the configuration: bit 0 trigger enable, bits 3:1 trigger line select, bit 4 low-resolution, bit 5 sleep, bits 13:8 PRESCAL, bits 22:16 STARTUP, bits 27:24 SHTIM. All other bits are dropped on write, so writing all ones reads back 0x0F7F3F3F.
- R3: A one in bit n written to address 2 selects input n, and a one written to address 3 deselects it. Zero bits change nothing. Address 4 reads the selected set in bits 7:0.
- R4: Writing ones to address 7 sets interrupt enables, and writing ones to address 8 clears them. Address 9 reads the enables, and only bits 19:0 exist.
- R5: A start converts each selected input once, in ascending order, with `conv_chan` giving the input. A start while a scan runs, or while no input is selected, is ignored. `conv_req` stays high and `conv_chan` stays stable until `conv_ack`.
- R6: Counted from the clock edge that accepts a start, the k-th request (k from 0) of a scan is acknowledged-ready at W + S + k*(S+1) cycles. Here D=(PRESCAL+1)*2, S=SHTIM*D, W=(STARTUP+1)*8*D when the converter is asleep, and W=0 otherwise. This assumes a converter that acknowledges in the same cycle.
- R7: The converter leaves sleep at its first scan after reset. When the sleep bit is 0 it stays awake, and when the sleep bit is 1 it returns to sleep when a scan ends.
- R8: Results are stored in the per-input register at address 16+n and in the most-recent register at address 6. In low-resolution mode the stored value is the upper 8 bits of the result, right-justified.
- R9: Address 5 reads status: bits 7:0 per-input completion, bits 15:8 per-input overrun, bit 16 ready. A result sets the input's completion bit and the ready bit. Reading address 16+n clears completion bit n, reading address 6 clears ready, and reading address 5 clears all overrun bits.
- R10: A result for input n that arrives while completion bit n is still set also sets overrun bit 8+n.
- R11: `irq` is high exactly when some status bit is set whose enable bit is also set.
- R12: With trigger enable set, a rising edge on `hw_trig[sel]` starts a scan and the other lines are ignored. With trigger enable clear, every line is ignored.
- R13: Address 0 is control: bit 1 starts a scan and bit 0 returns every register and the sequencer to the reset state. A reset in the same write as a start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read effects) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| hw_trig | input | 8 | Hardware trigger lines |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 3 | Input to convert |
| conv_ack | input | 1 | Converter returns a result this cycle |
| conv_result | input | 10 | Raw conversion result |
| irq | output | 1 | Interrupt request |

## Verification
Register effects are visible on `reg_rdata` in the cycle after the write edge. Clear-on-read effects are visible on the next read. The bench timestamps each handshake against the edge that accepted the start and compares it with the W + S + k*(S+1) schedule. It does this for a sweep of PRESCAL 0..2, STARTUP 0..1, SHTIM in {0,1,3} and four selection patterns. It uses a converter model that acknowledges in the same cycle and samples on the falling edge, so every timestamp is an exact whole cycle count. Stored data, flags and `irq` are read only after the last handshake of a scan has been logged and two further cycles have passed.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [7:0]       hw_trig,
  output logic             conv_req,
  output logic [2:0]       conv_chan,
  input  logic             conv_ack,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);
  localparam int NCH = 8;
  localparam int CW = $clog2(NCH);
  localparam logic [31:0] MODE_KEEP = 32'h0F7F_3F3F;
  localparam logic [4:0] A_CTRL = 5'd0, A_MODE = 5'd1, A_CHSET = 5'd2, A_CHCLR = 5'd3,
                         A_CHST = 5'd4, A_STAT = 5'd5, A_LAST = 5'd6, A_IESET = 5'd7,
                         A_IECLR = 5'd8, A_IEMASK = 5'd9;

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_SAMPLE, S_CONV} st_t;

  logic [31:0] mode_q;
  logic [NCH-1:0] chen_q, eoc_q, ovr_q, trig_q;
  logic [NCH-1:0] eoc_n, ovr_n;
  logic drdy_q, drdy_n, awake_q;
  logic [19:0] ie_q;
  logic [RES_W-1:0] data_q [NCH];
  logic [RES_W-1:0] last_q;
  st_t st_q, after_wake;
  logic [CW-1:0] ch_q;
  logic [7:0] div_q;
  logic [9:0] tk_q;

  function automatic logic [CW:0] next_en(input logic [NCH-1:0] en, input int from);
    logic [CW:0] r;
    r = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (i >= from && en[i]) r = {1'b1, CW'(i)};
    return r;
  endfunction

  wire [5:0] presc   = mode_q[13:8];
  wire [6:0] wake_f  = mode_q[22:16];
  wire [3:0] sh      = mode_q[27:24];
  wire       lowres  = mode_q[4];
  wire       sleep   = mode_q[5];
  wire       trg_en  = mode_q[0];
  wire [2:0] trg_sel = mode_q[3:1];

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire sw_rst   = wr_ctrl && reg_wdata[0];
  wire hw_go    = trg_en && hw_trig[trg_sel] && !trig_q[trg_sel];
  wire [CW:0] first = next_en(chen_q, 0);
  wire [CW:0] nxt   = next_en(chen_q, int'(ch_q) + 1);
  wire go       = ((wr_ctrl && reg_wdata[1]) || hw_go) && st_q == S_IDLE && first[CW];
  wire [7:0] div_last  = {1'b0, presc, 1'b1};
  wire [9:0] wake_last = {wake_f, 3'b111};
  wire tick      = div_q == div_last;
  wire conv_done = st_q == S_CONV && conv_ack;
  wire [RES_W-1:0] res_fmt = lowres ? (conv_result >> (RES_W - 8)) : conv_result;
  wire [31:0] status = {15'b0, drdy_q, ovr_q, eoc_q};

  assign after_wake = (sh == 4'd0) ? S_CONV : S_SAMPLE;
  assign conv_req   = st_q == S_CONV;
  assign conv_chan  = ch_q;
  assign irq        = |(status[19:0] & ie_q);

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      st_q <= S_IDLE; ch_q <= '0; awake_q <= 1'b0;
      div_q <= '0; tk_q <= '0; trig_q <= '0;
    end else begin
      trig_q <= hw_trig;
      div_q <= tick ? '0 : div_q + 8'd1;
      case (st_q)
        S_IDLE: if (go) begin
          ch_q <= first[CW-1:0];
          st_q <= awake_q ? after_wake : S_WAKE;
          div_q <= '0; tk_q <= '0;
        end
        S_WAKE: if (tick) begin
          if (tk_q == wake_last) begin
            st_q <= after_wake; awake_q <= 1'b1; tk_q <= '0; div_q <= '0;
          end else tk_q <= tk_q + 10'd1;
        end
        S_SAMPLE: if (tick) begin
          if (tk_q == {6'b0, sh - 4'd1}) begin
            st_q <= S_CONV; tk_q <= '0; div_q <= '0;
          end else tk_q <= tk_q + 10'd1;
        end
        S_CONV: if (conv_ack) begin
          div_q <= '0; tk_q <= '0;
          if (nxt[CW]) begin
            ch_q <= nxt[CW-1:0]; st_q <= after_wake;
          end else begin
            st_q <= S_IDLE;
            if (sleep) awake_q <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    eoc_n = eoc_q; ovr_n = ovr_q; drdy_n = drdy_q;
    if (reg_rd && reg_addr[4:3] == 2'b10) eoc_n[reg_addr[2:0]] = 1'b0;
    if (reg_rd && reg_addr == A_STAT) ovr_n = '0;
    if (reg_rd && reg_addr == A_LAST) drdy_n = 1'b0;
    if (conv_done) begin
      if (eoc_n[ch_q]) ovr_n[ch_q] = 1'b1;
      eoc_n[ch_q] = 1'b1;
      drdy_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      mode_q <= '0; chen_q <= '0; ie_q <= '0;
      eoc_q <= '0; ovr_q <= '0; drdy_q <= 1'b0; last_q <= '0;
      for (int i = 0; i < NCH; i++) data_q[i] <= '0;
    end else begin
      eoc_q <= eoc_n; ovr_q <= ovr_n; drdy_q <= drdy_n;
      if (conv_done) begin
        data_q[ch_q] <= res_fmt;
        last_q <= res_fmt;
      end
      if (reg_wr)
        case (reg_addr)
          A_MODE:  mode_q <= reg_wdata & MODE_KEEP;
          A_CHSET: chen_q <= chen_q | reg_wdata[7:0];
          A_CHCLR: chen_q <= chen_q & ~reg_wdata[7:0];
          A_IESET: ie_q <= ie_q | reg_wdata[19:0];
          A_IECLR: ie_q <= ie_q & ~reg_wdata[19:0];
          default: ;
        endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:   reg_rdata = mode_q;
      A_CHST:   reg_rdata = {24'b0, chen_q};
      A_STAT:   reg_rdata = status;
      A_LAST:   reg_rdata = 32'(last_q);
      A_IEMASK: reg_rdata = {12'b0, ie_q};
      default:  if (reg_addr[4:3] == 2'b10) reg_rdata = 32'(data_q[reg_addr[2:0]]);
    endcase
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_ack && !sw_rst |=> conv_req && $stable(conv_chan));

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !sw_rst |=> st_q == S_IDLE || ch_q > $past(ch_q));

  assert_result_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !sw_rst |=> eoc_q[$past(ch_q)] && drdy_q);

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && eoc_q[ch_q] && !reg_rd && !sw_rst |=> ovr_q[$past(ch_q)]);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q == 20'd0 |-> !irq);
endmodule

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] hw_trig = '0;
  logic conv_req, conv_ack, irq;
  logic [2:0] conv_chan;
  logic [9:0] conv_result;
  int seed = 0;
  int total = 0, bad = 0;
  int cyc = 0, start_cyc = 0, log_n = 0;
  int log_ch [16];
  int log_cyc [16];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign conv_ack = conv_req;
  assign conv_result = 10'((int'(conv_chan) * 149 + seed) % 1024);

  adc_scan_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack),
    .conv_result(conv_result), .irq(irq));

  always @(negedge clk)
    if (conv_req && conv_ack && log_n < 16) begin
      log_ch[log_n] = int'(conv_chan);
      log_cyc[log_n] = cyc - start_cyc;
      log_n = log_n + 1;
    end

  function automatic int res_of(int ch, int sd);
    return (ch * 149 + sd) % 1024;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic start_scan();
    log_n = 0;
    wr(5'd0, 32'h2);
    start_cyc = cyc;
  endtask

  task automatic wait_logs(int n);
    for (int t = 0; t < 600 && log_n < n; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_trig(int line);
    @(negedge clk); hw_trig[line] = 1'b1;
    @(negedge clk); hw_trig[line] = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'h01; pats[1] = 8'hA5; pats[2] = 8'h80; pats[3] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 conv_req", {31'b0, conv_req}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(5'd1, v); check("R1 mode", v, 0);
    rd(5'd4, v); check("R1 chstate", v, 0);
    rd(5'd5, v); check("R1 status", v, 0);
    rd(5'd6, v); check("R1 last", v, 0);
    rd(5'd9, v); check("R1 mask", v, 0);

    // R2 reserved bits dropped
    wr(5'd1, 32'hFFFF_FFFF); rd(5'd1, v); check("R2 mode all ones", v, 32'h0F7F_3F3F);
    wr(5'd1, 32'h1234_5678); rd(5'd1, v); check("R2 mode pattern", v, 32'h1234_5678 & 32'h0F7F_3F3F);

    // R3 set / clear selection
    wr(5'd2, 32'h81); rd(5'd4, v); check("R3 set", v, 32'h81);
    wr(5'd2, 32'h00); rd(5'd4, v); check("R3 zero set", v, 32'h81);
    wr(5'd3, 32'h01); rd(5'd4, v); check("R3 clear", v, 32'h80);
    wr(5'd3, 32'h00); rd(5'd4, v); check("R3 zero clear", v, 32'h80);
    wr(5'd2, 32'h06); rd(5'd4, v); check("R3 set more", v, 32'h86);

    // R4 interrupt enable set / clear
    wr(5'd7, 32'hFFFF_FFFF); rd(5'd9, v); check("R4 mask set", v, 32'h000F_FFFF);
    wr(5'd8, 32'h0000_000F); rd(5'd9, v); check("R4 mask clear", v, 32'h000F_FFF0);

    // R13 soft reset
    wr(5'd0, 32'h3);
    rd(5'd1, v); check("R13 mode after reset", v, 0);
    rd(5'd4, v); check("R13 chstate after reset", v, 0);
    rd(5'd9, v); check("R13 mask after reset", v, 0);

    // R5/R6/R8 sweep: order, timing and stored data
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 2; s++)
        for (int hi = 0; hi < 3; hi++)
          for (int q = 0; q < 4; q++) begin
            int h, d, w, sm, n;
            int exp_ch [8];
            h = (hi == 2) ? 3 : hi;
            d = (p + 1) * 2; w = (s + 1) * 8 * d; sm = h * d;
            n = 0;
            for (int c = 0; c < 8; c++) if (pats[q][c]) begin exp_ch[n] = c; n++; end
            seed = p * 101 + s * 53 + hi * 17 + q * 7;
            wr(5'd0, 32'h1);
            wr(5'd1, 32'(h << 24) | 32'(s << 16) | 32'(p << 8) | 32'h20);
            wr(5'd2, {24'b0, pats[q]});
            start_scan();
            wait_logs(n);
            check("R5 request count", 32'(log_n), 32'(n));
            for (int k = 0; k < n; k++) begin
              check("R5 ascending order", 32'(log_ch[k]), 32'(exp_ch[k]));
              check("R6 request timing", 32'(log_cyc[k]), 32'(w + sm + k * (sm + 1)));
            end
            for (int k = 0; k < n; k++) begin
              rd(5'(16 + exp_ch[k]), v);
              check("R8 channel data", v, 32'(res_of(exp_ch[k], seed)));
            end
            rd(5'd6, v); check("R8 last data", v, 32'(res_of(exp_ch[n-1], seed)));
          end

    // R7 sleep behaviour: D=2, W=16, S=2
    wr(5'd0, 32'h1);
    wr(5'd1, 32'h0100_0000);
    wr(5'd2, 32'h01);
    start_scan(); wait_logs(1); check("R7 first scan wakes", 32'(log_cyc[0]), 18);
    start_scan(); wait_logs(1); check("R7 stays awake", 32'(log_cyc[0]), 2);
    wr(5'd1, 32'h0100_0020);
    start_scan(); wait_logs(1); check("R7 still awake before sleep", 32'(log_cyc[0]), 2);
    start_scan(); wait_logs(1); check("R7 wakes again", 32'(log_cyc[0]), 18);

    // R5 start while busy ignored: D=4, W=64, S=0
    wr(5'd0, 32'h1);
    wr(5'd1, 32'h0001_0120);
    wr(5'd2, 32'h06);
    start_scan();
    repeat (10) @(negedge clk);
    wr(5'd0, 32'h2);
    wait_logs(2); repeat (100) @(negedge clk);
    check("R5 busy start count", 32'(log_n), 2);
    check("R5 busy start timing 0", 32'(log_cyc[0]), 64);
    check("R5 busy start timing 1", 32'(log_cyc[1]), 65);
    wr(5'd3, 32'hFF);
    start_scan(); repeat (200) @(negedge clk);
    check("R5 start without channels", 32'(log_n), 0);

    // R8 low resolution
    wr(5'd0, 32'h1);
    seed = 733;
    wr(5'd1, 32'h10);
    wr(5'd2, 32'h08);
    start_scan(); wait_logs(1);
    rd(5'd19, v); check("R8 low-res channel", v, 32'(res_of(3, seed) >> 2));
    rd(5'd6, v);  check("R8 low-res last", v, 32'(res_of(3, seed) >> 2));

    // R9/R10 status flags and overrun
    wr(5'd0, 32'h1);
    wr(5'd1, 32'h0);
    wr(5'd2, 32'h03);
    start_scan(); wait_logs(2);
    rd(5'd5, v); check("R9 status after scan", v, 32'h0001_0003);
    start_scan(); wait_logs(2);
    rd(5'd5, v); check("R10 overrun set", v, 32'h0001_0303);
    rd(5'd5, v); check("R9 status read clears overrun", v, 32'h0001_0003);
    rd(5'd16, v);
    rd(5'd5, v); check("R9 data read clears completion", v, 32'h0001_0002);
    rd(5'd6, v);
    rd(5'd5, v); check("R9 last read clears ready", v, 32'h0000_0002);

    // R11 interrupt
    wr(5'd7, 32'h0001_0000);
    @(negedge clk); check("R11 irq idle", {31'b0, irq}, 0);
    start_scan(); wait_logs(2);
    check("R11 irq on ready", {31'b0, irq}, 1);
    rd(5'd6, v);
    @(negedge clk); check("R11 irq after ready cleared", {31'b0, irq}, 0);
    wr(5'd7, 32'h2);
    @(negedge clk); check("R11 irq on completion 1", {31'b0, irq}, 1);
    wr(5'd8, 32'h2);
    @(negedge clk); check("R11 irq disabled", {31'b0, irq}, 0);

    // R12 hardware trigger, line select 5
    wr(5'd0, 32'h1);
    wr(5'd1, 32'h0000_000B);
    wr(5'd2, 32'h10);
    log_n = 0;
    pulse_trig(4); repeat (20) @(negedge clk);
    check("R12 other line ignored", 32'(log_n), 0);
    pulse_trig(5); wait_logs(1);
    check("R12 selected line starts", 32'(log_n), 1);
    check("R12 channel", 32'(log_ch[0]), 4);
    wr(5'd1, 32'h0000_000A);
    log_n = 0;
    pulse_trig(5); repeat (20) @(negedge clk);
    check("R12 disabled trigger ignored", 32'(log_n), 0);

    // R13 reset wins over start in one write
    wr(5'd2, 32'h01);
    log_n = 0;
    wr(5'd0, 32'h3); repeat (20) @(negedge clk);
    check("R13 reset beats start", 32'(log_n), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R5: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule